// File: doc/BRIEF.md
# Mirrored Dual-View Word Store

This block is an on-chip SRAM that two buses reach through two separate address windows. The data view is byte-addressed: each request reads or writes one byte. The instruction view reads whole 32-bit words. Both views reach the same storage, but in opposite word order. Walking upward through the data window visits the instruction words from the top of the instruction window down to its base. Within any one word the byte lanes keep little-endian order in both views.

The mirror is computed as a subtraction from the top word index. It is not a bit inversion of the address. The window bases and the storage depth are parameters. The default build has 512 words. The full-size build uses `WORD_AW = 15`: its data window is 0x3FFE_0000 to 0x3FFF_FFFF and its instruction window is 0x400A_0000 to 0x400B_FFFF.

Each view has a valid/ready request channel and a valid/ready response channel. A request is accepted in a cycle where both `*_req_valid` and `*_req_ready` are high. The requester must hold the request stable until it is accepted. A response stays valid, with unchanged data, until the cycle where `*_rsp_ready` is high. Request ready is high exactly when that view's response register is empty or is being drained in the same cycle. Each view therefore stalls only on its own response channel.

Top module: `mirrored_dual_sram`

## Requirements
- R1: Data byte address DATA_BASE + 4k + b (k < DEPTH, b < 4) refers to bits [8b+7:8b] of the instruction word at INSTR_BASE + 4·(DEPTH−1−k). A data read returns that byte in `d_rsp_data`.
- R2: Mirroring is subtractive: data word k = 0 pairs with the highest instruction word. Data word DEPTH−1 (byte address DATA_BASE + 4·DEPTH − 4) pairs with the instruction word at INSTR_BASE.
- R3: A data write changes only the one addressed byte lane. The other three bytes of that word keep their contents.
- R4: An accepted read on either view raises that view's response valid in the next cycle, with the read data.
- R5: The instruction view ignores address bits [1:0] and always returns the whole aligned word.
- R6: A request outside its view's window does not touch storage. An out-of-window read still produces a response, and its data is zero.
- R7: If an instruction read and a data write address the same word in the same cycle, the read returns the contents before the write. A later read returns the new contents.
- R8: While a response is valid and its ready is low, the same view's request ready is low. In that state the response stays valid and its data stays stable.
- R9: A data write produces no response. Request ready is high whenever the view's response register is empty.
- R10: After reset, both response valids are low and both request readies are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| d_req_valid | input | 1 | Data view request valid |
| d_req_ready | output | 1 | Data view request ready |
| d_req_addr | input | ADDR_W | Data view byte address |
| d_req_write | input | 1 | 1 = write byte, 0 = read byte |
| d_req_wdata | input | 8 | Byte to write |
| d_rsp_valid | output | 1 | Data view response valid |
| d_rsp_ready | input | 1 | Data view response ready |
| d_rsp_data | output | 8 | Byte read |
| i_req_valid | input | 1 | Instruction view request valid |
| i_req_ready | output | 1 | Instruction view request ready |
| i_req_addr | input | ADDR_W | Instruction view address; bits [1:0] ignored |
| i_rsp_valid | output | 1 | Instruction view response valid |
| i_rsp_ready | input | 1 | Instruction view response ready |
| i_rsp_data | output | 32 | Word read |

## Verification
Every read response is due exactly one cycle after its request is accepted. Storage written at an edge is visible to a read accepted at any later edge. A same-edge instruction read sees the old word. The bench keeps a behavioural model that is updated at each rising edge, in the same order the storage uses: instruction read first, then data write. It compares ready, valid and data against the model 5 ns after every edge. Directed checks drive requests at the falling edge and sample the response at the next falling edge, which is the first point where the registered result is due. The back-pressure test samples across two stalled cycles.

// File: rtl/mds_pkg.sv
`timescale 1ns/1ps
package mds_pkg;
  localparam int LANES  = 4;
  localparam int BYTE_W = 8;
  localparam int WORD_W = LANES * BYTE_W;

  typedef logic [1:0]        lane_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/mds_window_decode.sv
`timescale 1ns/1ps
// Address window match: in-range flag, word offset and byte lane.
module mds_window_decode #(
  parameter int                ADDR_W  = 32,
  parameter int                WORD_AW = 9,
  parameter logic [ADDR_W-1:0] BASE    = '0
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               hit,
  output logic [WORD_AW-1:0] word_idx,
  output mds_pkg::lane_t     lane
);
  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset   = addr - BASE;
    // An address below BASE wraps to a large offset and misses.
    hit      = ~|offset[ADDR_W-1:WORD_AW+2];
    word_idx = offset[WORD_AW+1:2];
    lane     = offset[1:0];
  end
endmodule

// File: rtl/mds_word_store.sv
`timescale 1ns/1ps
// Storage built as one byte-wide array per lane.
// Port A and port B read; the byte write reads-before-writes.
module mds_word_store #(
  parameter int WORD_AW = 9
) (
  input  logic                 clk,
  input  logic                 wr_en,
  input  logic [WORD_AW-1:0]   wr_idx,
  input  mds_pkg::lane_t       wr_lane,
  input  mds_pkg::byte_t       wr_byte,
  input  logic                 a_en,
  input  logic [WORD_AW-1:0]   a_idx,
  output mds_pkg::word_t       a_q,
  input  logic                 b_en,
  input  logic [WORD_AW-1:0]   b_idx,
  output mds_pkg::word_t       b_q
);
  import mds_pkg::*;
  localparam int DEPTH = 1 << WORD_AW;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    byte_t cells [DEPTH];
    byte_t qa;
    byte_t qb;
    logic  sel;

    assign sel = wr_en && (wr_lane == lane_t'(g));

    always_ff @(posedge clk) begin
      if (sel)  cells[wr_idx] <= wr_byte;
      if (a_en) qa <= cells[a_idx];
      if (b_en) qb <= cells[b_idx];
    end

    assign a_q[g*BYTE_W +: BYTE_W] = qa;
    assign b_q[g*BYTE_W +: BYTE_W] = qb;
  end
endmodule

// File: rtl/mds_rsp_slot.sv
`timescale 1ns/1ps
// One-entry response slot: controls acceptance, store read enable
// and the registered valid, window flag and tag.
module mds_rsp_slot #(
  parameter int TAG_W = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_is_read,
  input  logic             req_hit,
  input  logic [TAG_W-1:0] req_tag,
  input  logic             rsp_ready,
  output logic             req_ready,
  output logic             req_accept,
  output logic             store_en,
  output logic             rsp_valid,
  output logic             hit_q,
  output logic [TAG_W-1:0] tag_q
);
  logic take;

  always_comb begin
    req_ready  = !rsp_valid || rsp_ready;
    req_accept = req_valid && req_ready;
    take       = req_accept && req_is_read;
    store_en   = take && req_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      hit_q     <= 1'b0;
      tag_q     <= '0;
    end else if (take) begin
      rsp_valid <= 1'b1;
      hit_q     <= req_hit;
      tag_q     <= req_tag;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/mirrored_dual_sram.sv
`timescale 1ns/1ps
// Shared storage seen as byte data and as instruction words in mirrored word order.
module mirrored_dual_sram #(
  parameter int                ADDR_W     = 32,
  parameter int                WORD_AW    = 9,
  parameter logic [ADDR_W-1:0] DATA_BASE  = 'h3FFE_0000,
  parameter logic [ADDR_W-1:0] INSTR_BASE = 'h400A_0000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              d_req_valid,
  output logic              d_req_ready,
  input  logic [ADDR_W-1:0] d_req_addr,
  input  logic              d_req_write,
  input  logic [7:0]        d_req_wdata,
  output logic              d_rsp_valid,
  input  logic              d_rsp_ready,
  output logic [7:0]        d_rsp_data,
  input  logic              i_req_valid,
  output logic              i_req_ready,
  input  logic [ADDR_W-1:0] i_req_addr,
  output logic              i_rsp_valid,
  input  logic              i_rsp_ready,
  output logic [31:0]       i_rsp_data
);
  import mds_pkg::*;

  localparam int                 DEPTH   = 1 << WORD_AW;
  localparam logic [WORD_AW-1:0] TOP_IDX = WORD_AW'(DEPTH - 1);

  logic               d_hit, i_hit;
  logic [WORD_AW-1:0] d_widx, i_widx, d_phys;
  lane_t              d_lane, i_lane_unused;
  logic               d_accept, d_rd_en, d_hit_q, d_wr_en;
  lane_t              d_lane_q;
  logic               i_accept_unused, i_rd_en, i_hit_q;
  logic [0:0]         i_tag_unused;
  word_t              d_word_q, i_word_q;

  mds_window_decode #(.ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .BASE(DATA_BASE)) u_d_dec (
    .addr(d_req_addr), .hit(d_hit), .word_idx(d_widx), .lane(d_lane)
  );

  mds_window_decode #(.ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .BASE(INSTR_BASE)) u_i_dec (
    .addr(i_req_addr), .hit(i_hit), .word_idx(i_widx), .lane(i_lane_unused)
  );

  // Physical order follows the instruction view; the data view is mirrored.
  assign d_phys = TOP_IDX - d_widx;

  mds_rsp_slot #(.TAG_W(2)) u_d_slot (
    .clk(clk), .rst_n(rst_n),
    .req_valid(d_req_valid), .req_is_read(!d_req_write), .req_hit(d_hit),
    .req_tag(d_lane), .rsp_ready(d_rsp_ready),
    .req_ready(d_req_ready), .req_accept(d_accept), .store_en(d_rd_en),
    .rsp_valid(d_rsp_valid), .hit_q(d_hit_q), .tag_q(d_lane_q)
  );

  mds_rsp_slot #(.TAG_W(1)) u_i_slot (
    .clk(clk), .rst_n(rst_n),
    .req_valid(i_req_valid), .req_is_read(1'b1), .req_hit(i_hit),
    .req_tag(1'b0), .rsp_ready(i_rsp_ready),
    .req_ready(i_req_ready), .req_accept(i_accept_unused), .store_en(i_rd_en),
    .rsp_valid(i_rsp_valid), .hit_q(i_hit_q), .tag_q(i_tag_unused)
  );

  assign d_wr_en = d_accept && d_req_write && d_hit;

  mds_word_store #(.WORD_AW(WORD_AW)) u_store (
    .clk(clk),
    .wr_en(d_wr_en), .wr_idx(d_phys), .wr_lane(d_lane), .wr_byte(d_req_wdata),
    .a_en(d_rd_en), .a_idx(d_phys), .a_q(d_word_q),
    .b_en(i_rd_en), .b_idx(i_widx), .b_q(i_word_q)
  );

  assign d_rsp_data = d_hit_q ? d_word_q[{d_lane_q, 3'b000} +: BYTE_W] : '0;
  assign i_rsp_data = i_hit_q ? i_word_q : '0;
endmodule

// File: rtl/mds_checker.sv
`timescale 1ns/1ps
module mds_checker #(
  parameter int                ADDR_W     = 32,
  parameter int                WORD_AW    = 9,
  parameter logic [ADDR_W-1:0] DATA_BASE  = 'h3FFE_0000,
  parameter logic [ADDR_W-1:0] INSTR_BASE = 'h400A_0000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              d_req_valid,
  input logic              d_req_ready,
  input logic [ADDR_W-1:0] d_req_addr,
  input logic              d_req_write,
  input logic              d_rsp_valid,
  input logic              d_rsp_ready,
  input logic [7:0]        d_rsp_data,
  input logic              i_req_valid,
  input logic              i_req_ready,
  input logic [ADDR_W-1:0] i_req_addr,
  input logic              i_rsp_valid,
  input logic              i_rsp_ready,
  input logic [31:0]       i_rsp_data
);
  localparam logic [ADDR_W-1:0] SPAN = ADDR_W'(4 << WORD_AW);

  logic d_in, i_in, d_fire, i_fire;
  assign d_in   = (d_req_addr - DATA_BASE) < SPAN;
  assign i_in   = (i_req_addr - INSTR_BASE) < SPAN;
  assign d_fire = d_req_valid && d_req_ready;
  assign i_fire = i_req_valid && i_req_ready;

  p_d_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    d_rsp_valid && !d_rsp_ready |-> !d_req_ready);
  p_i_blocked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    i_rsp_valid && !i_rsp_ready |-> !i_req_ready);
  p_d_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    d_rsp_valid && !d_rsp_ready |=> d_rsp_valid && $stable(d_rsp_data));
  p_i_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    i_rsp_valid && !i_rsp_ready |=> i_rsp_valid && $stable(i_rsp_data));
  p_d_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    d_fire && !d_req_write |=> d_rsp_valid);
  p_i_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    i_fire |=> i_rsp_valid);
  p_write_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    d_fire && d_req_write |=> !d_rsp_valid);
  p_d_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !d_rsp_valid |-> d_req_ready);
  p_d_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    d_fire && !d_req_write && !d_in |=> d_rsp_data == 8'h00);
  p_i_outside_r6: assert property (@(posedge clk) disable iff (!rst_n)
    i_fire && !i_in |=> i_rsp_data == 32'h0);
endmodule

bind mirrored_dual_sram mds_checker #(
  .ADDR_W(ADDR_W), .WORD_AW(WORD_AW), .DATA_BASE(DATA_BASE), .INSTR_BASE(INSTR_BASE)
) u_mds_checker (
  .clk(clk), .rst_n(rst_n),
  .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_req_addr(d_req_addr),
  .d_req_write(d_req_write), .d_rsp_valid(d_rsp_valid), .d_rsp_ready(d_rsp_ready),
  .d_rsp_data(d_rsp_data),
  .i_req_valid(i_req_valid), .i_req_ready(i_req_ready), .i_req_addr(i_req_addr),
  .i_rsp_valid(i_rsp_valid), .i_rsp_ready(i_rsp_ready), .i_rsp_data(i_rsp_data)
);

// File: tb/test_mirrored_dual_sram.sv
`timescale 1ns/1ps
module test_mirrored_dual_sram;
  localparam int          WORD_AW = 9;
  localparam int          DEPTH   = 1 << WORD_AW;
  localparam int unsigned SPAN    = 4 * DEPTH;
  localparam logic [31:0] DBASE   = 32'h3FFE_0000;
  localparam logic [31:0] IBASE   = 32'h400A_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        d_req_valid = 1'b0, d_req_write = 1'b0, d_rsp_ready = 1'b1;
  logic [31:0] d_req_addr = '0;
  logic [7:0]  d_req_wdata = '0;
  logic        i_req_valid = 1'b0, i_rsp_ready = 1'b1;
  logic [31:0] i_req_addr = '0;
  logic        d_req_ready, d_rsp_valid, i_req_ready, i_rsp_valid;
  logic [7:0]  d_rsp_data;
  logic [31:0] i_rsp_data;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  mirrored_dual_sram #(.WORD_AW(WORD_AW)) i_mirrored_dual_sram (
    .clk(clk), .rst_n(rst_n),
    .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_req_addr(d_req_addr),
    .d_req_write(d_req_write), .d_req_wdata(d_req_wdata),
    .d_rsp_valid(d_rsp_valid), .d_rsp_ready(d_rsp_ready), .d_rsp_data(d_rsp_data),
    .i_req_valid(i_req_valid), .i_req_ready(i_req_ready), .i_req_addr(i_req_addr),
    .i_rsp_valid(i_rsp_valid), .i_rsp_ready(i_rsp_ready), .i_rsp_data(i_rsp_data)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int k, input int b);
    return 8'((k * 37 + b * 101 + 3) & 255);
  endfunction

  function automatic logic [31:0] word_of(input int k);
    return {pat(k, 3), pat(k, 2), pat(k, 1), pat(k, 0)};
  endfunction

  // ---------------- behavioural reference model ----------------
  logic [31:0] ref_mem [DEPTH];
  bit          exp_dv = 0, exp_iv = 0;
  logic [7:0]  exp_dd = '0;
  logic [31:0] exp_id = '0;
  bit          m_drdy, m_irdy;
  int unsigned m_off;
  int          m_row;

  initial for (int j = 0; j < DEPTH; j++) ref_mem[j] = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      exp_dv = 0;
      exp_iv = 0;
    end else begin
      m_drdy = !exp_dv || d_rsp_ready;
      m_irdy = !exp_iv || i_rsp_ready;
      if (exp_dv && d_rsp_ready) exp_dv = 0;
      if (exp_iv && i_rsp_ready) exp_iv = 0;
      if (i_req_valid && m_irdy) begin
        m_off  = i_req_addr - IBASE;
        exp_iv = 1;
        exp_id = (m_off < SPAN) ? ref_mem[m_off / 4] : 32'h0;
      end
      if (d_req_valid && m_drdy) begin
        m_off = d_req_addr - DBASE;
        m_row = DEPTH - 1 - int'(m_off / 4);
        if (!d_req_write) begin
          exp_dv = 1;
          exp_dd = (m_off < SPAN) ? ref_mem[m_row][8 * (m_off % 4) +: 8] : 8'h00;
        end else if (m_off < SPAN) begin
          ref_mem[m_row][8 * (m_off % 4) +: 8] = d_req_wdata;
        end
      end
    end
  end

  // Per-cycle comparison, 5 ns after each rising edge.
  always begin
    @(posedge clk);
    #5;
    if (rst_n) begin
      chk("R8 d_req_ready", 32'(d_req_ready), 32'(!exp_dv || d_rsp_ready));
      chk("R8 i_req_ready", 32'(i_req_ready), 32'(!exp_iv || i_rsp_ready));
      chk("R4 d_rsp_valid", 32'(d_rsp_valid), 32'(exp_dv));
      chk("R4 i_rsp_valid", 32'(i_rsp_valid), 32'(exp_iv));
      if (exp_dv) chk("R1 d_rsp_data model", 32'(d_rsp_data), 32'(exp_dd));
      if (exp_iv) chk("R1 i_rsp_data model", i_rsp_data, exp_id);
    end
  end

  // ---------------- stimulus tasks ----------------
  task automatic d_write(input logic [31:0] a, input logic [7:0] v);
    @(negedge clk);
    d_req_valid = 1'b1; d_req_write = 1'b1; d_req_addr = a; d_req_wdata = v;
    @(negedge clk);
    d_req_valid = 1'b0; d_req_write = 1'b0;
  endtask

  task automatic d_read(input logic [31:0] a, output logic vld, output logic [7:0] v);
    @(negedge clk);
    d_req_valid = 1'b1; d_req_write = 1'b0; d_req_addr = a;
    @(negedge clk);
    d_req_valid = 1'b0;
    vld = d_rsp_valid; v = d_rsp_data;
  endtask

  task automatic i_read(input logic [31:0] a, output logic vld, output logic [31:0] w);
    @(negedge clk);
    i_req_valid = 1'b1; i_req_addr = a;
    @(negedge clk);
    i_req_valid = 1'b0;
    vld = i_rsp_valid; w = i_rsp_data;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R4 watchdog expired: actual running expected done");
    finish_run();
  end

  initial begin
    logic        v;
    logic [7:0]  b8, held;
    logic [31:0] w;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 d_rsp_valid after reset", 32'(d_rsp_valid), 32'h0);
    chk("R10 i_rsp_valid after reset", 32'(i_rsp_valid), 32'h0);
    chk("R10 d_req_ready after reset", 32'(d_req_ready), 32'h1);
    chk("R10 i_req_ready after reset", 32'(i_req_ready), 32'h1);

    // Fill every byte through the data view.
    for (int k = 0; k < DEPTH; k++)
      for (int b = 0; b < 4; b++)
        d_write(DBASE + 32'(4 * k + b), pat(k, b));
    chk("R9 no response after write", 32'(d_rsp_valid), 32'h0);
    chk("R9 ready with empty slot", 32'(d_req_ready), 32'h1);

    // Every instruction word against the mirrored mapping.
    for (int j = 0; j < DEPTH; j++) begin
      i_read(IBASE + 32'(4 * j), v, w);
      chk("R1 mirrored word", w, word_of(DEPTH - 1 - j));
    end

    // Window ends.
    i_read(IBASE, v, w);
    chk("R2 base instr word = last data word", w, word_of(DEPTH - 1));
    i_read(IBASE + SPAN - 4, v, w);
    chk("R2 top instr word = first data word", w, word_of(0));

    // Byte read through the data view.
    d_read(DBASE + 32'(4 * 5 + 2), v, b8);
    chk("R4 data read valid", 32'(v), 32'h1);
    chk("R1 data byte lane 2", 32'(b8), 32'(pat(5, 2)));
    d_read(DBASE + SPAN - 1, v, b8);
    chk("R2 last data byte", 32'(b8), 32'(pat(DEPTH - 1, 3)));

    // Single-lane write.
    d_write(DBASE + 32'(4 * 9 + 1), 8'hA5);
    i_read(IBASE + 32'(4 * (DEPTH - 1 - 9)), v, w);
    chk("R3 only lane 1 changed", w, {pat(9, 3), pat(9, 2), 8'hA5, pat(9, 0)});

    // Low instruction address bits ignored.
    i_read(IBASE + 32'(4 * 7 + 3), v, w);
    chk("R5 unaligned instr address", w, word_of(DEPTH - 1 - 7));

    // Out-of-window accesses.
    d_write(DBASE - 1, 8'h5A);
    d_write(DBASE + SPAN, 8'h5A);
    i_read(IBASE + SPAN - 4, v, w);
    chk("R6 write below window ignored", w, word_of(0));
    i_read(IBASE, v, w);
    chk("R6 write above window ignored", w, word_of(DEPTH - 1));
    d_read(DBASE + SPAN, v, b8);
    chk("R6 data read outside valid", 32'(v), 32'h1);
    chk("R6 data read outside zero", 32'(b8), 32'h0);
    i_read(IBASE + SPAN, v, w);
    chk("R6 instr read above zero", w, 32'h0);
    i_read(IBASE - 4, v, w);
    chk("R6 instr read below zero", w, 32'h0);

    // Same-cycle collision: instruction read sees old word.
    @(negedge clk);
    d_req_valid = 1'b1; d_req_write = 1'b1;
    d_req_addr = DBASE + 32'(4 * 12); d_req_wdata = 8'hC3;
    i_req_valid = 1'b1; i_req_addr = IBASE + 32'(4 * (DEPTH - 1 - 12));
    @(negedge clk);
    d_req_valid = 1'b0; d_req_write = 1'b0; i_req_valid = 1'b0;
    chk("R7 collision returns old word", i_rsp_data, word_of(12));
    i_read(IBASE + 32'(4 * (DEPTH - 1 - 12)), v, w);
    chk("R7 later read sees new byte", w, {word_of(12)[31:8], 8'hC3});

    // Back-pressure on the data response.
    @(negedge clk);
    d_rsp_ready = 1'b0;
    d_req_valid = 1'b1; d_req_write = 1'b0; d_req_addr = DBASE + 32'(4 * 20 + 3);
    @(negedge clk);
    chk("R8 response valid while stalled", 32'(d_rsp_valid), 32'h1);
    chk("R8 request blocked while stalled", 32'(d_req_ready), 32'h0);
    held = d_rsp_data;
    d_req_addr = DBASE + 32'(4 * 21);
    @(negedge clk);
    chk("R8 held data stable", 32'(d_rsp_data), 32'(held));
    chk("R8 held data value", 32'(d_rsp_data), 32'(pat(20, 3)));
    d_req_valid = 1'b0; d_rsp_ready = 1'b1;
    @(negedge clk);
    chk("R8 drained without new response", 32'(d_rsp_valid), 32'h0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule